// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block times programmed-I/O transfers on a parallel ATA host with two channels, each carrying a master and a slave drive. A small byte-addressed configuration bank holds the settings. It contains a control byte with one enable bit per channel and a bus-master DMA enable bit. It also holds one address-setup count. The remaining entries are timing bytes: one per channel for command-block cycles, and one per channel, drive and direction for data reads and writes. Each timing byte packs a recovery count and a strobe-assert count.

A cycle request names a channel, a drive, a direction and whether it is a command-block access. When the block is idle and the channel is enabled, it latches the timing for that target. It then steps through three phases: address setup, strobe active, and recovery. A one-clock done pulse closes the cycle. The read or write strobe is driven low only during the active phase.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset, the control byte (offset 0x60) reads 0x03, the setup byte (0x61) reads 0x03 and all ten timing bytes (0x62 to 0x6B) read 0xB6.
- R2: Timing bytes at 0x62 to 0x6B read back exactly what was written. Offsets outside 0x60 to 0x6B read 0x00, and writes to them have no effect. The setup byte keeps only bits 3:0 and reads 0 in bits 7:4.
- R3: In the control byte, bit 0 enables channel 0, bit 1 enables channel 1 and bit 6 is the bus-master DMA enable. These three bits are read/write, and every other bit reads 0.
- R4: A timing byte holds the recovery count in bits 7:4 and the assert count in bits 3:0. A command-block cycle uses the byte at 0x62+channel. A read uses 0x64+4*channel+drive, and a write uses 0x66+4*channel+drive.
- R5: A request to a channel whose enable bit is 0 starts no cycle: busy, done and both strobes stay inactive.
- R6: An accepted request is followed by SETUP for the setup count, ACTIVE for the assert count and RECOVER for the recovery count. Busy is high through all three phases, and then done is high for exactly one clock with busy low.
- R7: The read strobe (active low) is low only in ACTIVE of a read cycle, and the write strobe only in ACTIVE of a write cycle. The two are never low together.
- R8: A setup, assert or recovery count of 0 lasts 1 clock.
- R9: A request that arrives while busy or done is high is ignored. It neither restarts nor extends the cycle, and no second cycle follows it.
- R10: Counts are captured when a request is accepted. A configuration write during a cycle does not change that cycle's phase lengths.
- R11: While busy is high, cyc_chan and cyc_drive show the channel and drive of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational from cfg_addr) |
| req_valid | input | 1 | Cycle request, sampled while idle |
| req_chan | input | 1 | Requested channel |
| req_drive | input | 1 | Requested drive (0 master, 1 slave) |
| req_write | input | 1 | 1 for a write cycle, 0 for a read |
| req_cmd | input | 1 | 1 for a command-block access |
| busy | output | 1 | High from SETUP through RECOVER |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| cyc_chan | output | 1 | Channel of the running cycle |
| cyc_drive | output | 1 | Drive of the running cycle |

## Verification
The assertions assume that the request fields are stable in the cycle where req_valid is sampled. They also assume that reset is applied before the first request. The bench changes every input only on the falling clock edge. It holds req_valid for exactly one clock per intended request. It pulses extra requests only at known points inside a running cycle or during done, so the ignore checks have defined targets. Random configuration writes cover offsets slightly beyond the mapped range. Every count stays within 4 bits, so no cycle runs longer than 45 clocks.

// File: rtl/ata_pio_timer.sv
module ata_pio_timer #(
  parameter logic [7:0] BASE      = 8'h60,
  parameter logic [7:0] TIM_RST   = 8'hB6,
  parameter logic [3:0] SETUP_RST = 4'd3,
  parameter int         NT        = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       req_valid,
  input  logic       req_chan,
  input  logic       req_drive,
  input  logic       req_write,
  input  logic       req_cmd,
  output logic       busy,
  output logic       done,
  output logic       rd_strobe_n,
  output logic       wr_strobe_n,
  output logic       cyc_chan,
  output logic       cyc_drive
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACTIVE, S_RECOVER, S_DONE} st_t;

  st_t        st;
  logic [1:0] chan_en;
  logic       dma_en;
  logic [3:0] setup_len;
  logic [7:0] tim [0:NT-1];
  logic [3:0] cnt, a_m1, r_m1;
  logic       wr_q;

  logic [7:0] off;
  logic       in_tim;
  logic [3:0] widx, sel;
  logic [7:0] sel_byte;
  logic       accept;

  function automatic logic [3:0] m1(input logic [3:0] v);
    return (v == 4'd0) ? 4'd0 : v - 4'd1;
  endfunction

  assign off    = cfg_addr - BASE;
  assign in_tim = (off >= 8'd2) && (off < 8'(NT + 2));
  assign widx   = off[3:0] - 4'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en   <= 2'b11;
      dma_en    <= 1'b0;
      setup_len <= SETUP_RST;
      for (int i = 0; i < NT; i++) tim[i] <= TIM_RST;
    end else if (cfg_we) begin
      if (off == 8'd0) begin
        chan_en <= cfg_wdata[1:0];
        dma_en  <= cfg_wdata[6];
      end else if (off == 8'd1) begin
        setup_len <= cfg_wdata[3:0];
      end else if (in_tim) begin
        tim[widx] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (off == 8'd0)      cfg_rdata = {1'b0, dma_en, 4'b0000, chan_en};
    else if (off == 8'd1) cfg_rdata = {4'b0000, setup_len};
    else if (in_tim)      cfg_rdata = tim[widx];
  end

  assign sel = req_cmd ? {3'b000, req_chan}
                       : 4'd2 + (req_write ? 4'd2 : 4'd0)
                         + {1'b0, req_chan, 2'b00} + {3'b000, req_drive};
  assign sel_byte = tim[sel];
  assign accept   = (st == S_IDLE) && req_valid && chan_en[req_chan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= 4'd0;
      a_m1      <= 4'd0;
      r_m1      <= 4'd0;
      wr_q      <= 1'b0;
      cyc_chan  <= 1'b0;
      cyc_drive <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st        <= S_SETUP;
          cnt       <= m1(setup_len);
          a_m1      <= m1(sel_byte[3:0]);
          r_m1      <= m1(sel_byte[7:4]);
          wr_q      <= req_write;
          cyc_chan  <= req_chan;
          cyc_drive <= req_drive;
        end
        S_SETUP: if (cnt == 4'd0) begin
          st  <= S_ACTIVE;
          cnt <= a_m1;
        end else cnt <= cnt - 4'd1;
        S_ACTIVE: if (cnt == 4'd0) begin
          st  <= S_RECOVER;
          cnt <= r_m1;
        end else cnt <= cnt - 4'd1;
        S_RECOVER: if (cnt == 4'd0) st <= S_DONE;
                   else cnt <= cnt - 4'd1;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st == S_SETUP) || (st == S_ACTIVE) || (st == S_RECOVER);
  assign done        = (st == S_DONE);
  assign rd_strobe_n = !((st == S_ACTIVE) && !wr_q);
  assign wr_strobe_n = !((st == S_ACTIVE) && wr_q);

endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_chan,
  input logic [1:0] chan_en,
  input logic       busy,
  input logic       done,
  input logic       rd_strobe_n,
  input logic       wr_strobe_n,
  input logic       cyc_chan,
  input logic       cyc_drive
);

  a_r5_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && req_valid && !chan_en[req_chan]) |=> !busy);

  a_r6_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && req_valid && chan_en[req_chan]) |=> busy);

  a_r6_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n));

  a_r7_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_n || !wr_strobe_n) |-> busy);

  a_r11_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(cyc_chan) && $stable(cyc_drive))));

endmodule

bind ata_pio_timer ata_pio_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
  .chan_en(chan_en), .busy(busy), .done(done), .rd_strobe_n(rd_strobe_n),
  .wr_strobe_n(wr_strobe_n), .cyc_chan(cyc_chan), .cyc_drive(cyc_drive)
);

// File: tb/test_ata_pio_timer.sv
`timescale 1ns/1ps
module test_ata_pio_timer;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_chan = 0, req_drive = 0, req_write = 0, req_cmd = 0;
  logic busy, done, rd_strobe_n, wr_strobe_n, cyc_chan, cyc_drive;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] sh [0:255];

  always #4 clk = ~clk;

  ata_pio_timer i_ata_pio_timer (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void sh_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h60) sh[a] = d & 8'h43;
    else if (a == 8'h61) sh[a] = d & 8'h0F;
    else if (a >= 8'h62 && a <= 8'h6B) sh[a] = d;
  endfunction

  function automatic logic [7:0] sel_addr(input bit ch, input bit dr, input bit wr, input bit cmd);
    if (cmd) return 8'h62 + 8'(ch);
    return (wr ? 8'h66 : 8'h64) + 8'(4 * ch) + 8'(dr);
  endfunction

  function automatic int eff(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic wr_cfg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    sh_write(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    @(negedge clk); cfg_addr = a; #1;
    chk(req, $sformatf("read 0x%02h", a), int'(cfg_rdata), int'(sh[a]));
  endtask

  task automatic do_req(input bit ch, input bit dr, input bit wr, input bit cmd,
                        input bit inj, input bit midcfg, input logic [7:0] newval);
    logic [7:0] tb;
    int es, ea, er, ns, na, nr, wrong, tgt, idx;
    bit seen_done;
    tb = sh[sel_addr(ch, dr, wr, cmd)];
    es = eff(sh[8'h61][3:0]); ea = eff(tb[3:0]); er = eff(tb[7:4]);
    @(negedge clk);
    req_valid = 1; req_chan = ch; req_drive = dr; req_write = wr; req_cmd = cmd;
    @(negedge clk); req_valid = 0;
    if (!sh[8'h60][ch]) begin
      for (int k = 0; k < 3; k++) begin
        chk("R5", "busy on disabled channel", int'(busy), 0);
        chk("R5", "strobes on disabled channel", int'(rd_strobe_n & wr_strobe_n), 1);
        @(negedge clk);
      end
      return;
    end
    ns = 0; na = 0; nr = 0; wrong = 0; tgt = 0; seen_done = 0;
    for (idx = 0; idx < 100; idx++) begin
      if (done) begin seen_done = 1; break; end
      if (busy) begin
        if (cyc_chan != ch || cyc_drive != dr) tgt++;
        if ((wr ? rd_strobe_n : wr_strobe_n) == 0) wrong++;
        if ((wr ? wr_strobe_n : rd_strobe_n) == 0) na++;
        else if (na == 0) ns++;
        else nr++;
      end
      if (idx == 1 && midcfg) begin
        cfg_we = 1; cfg_addr = sel_addr(ch, dr, wr, cmd); cfg_wdata = newval;
      end
      if (idx == 2) cfg_we = 0;
      if (idx == 2 && inj) begin
        req_valid = 1; req_chan = !ch; req_write = !wr; req_cmd = 0;
      end
      if (idx == 3) req_valid = 0;
      @(negedge clk);
    end
    if (midcfg) sh_write(sel_addr(ch, dr, wr, cmd), newval);
    chk("R6", "done reached", int'(seen_done), 1);
    chk("R6/R8", "setup clocks", ns, es);
    chk("R4/R8/R10", "active clocks", na, ea);
    chk("R4/R8/R10", "recover clocks", nr, er);
    chk("R7", "wrong strobe clocks", wrong, 0);
    chk("R11", "target mismatches", tgt, 0);
    if (inj) req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R6/R9", "done single pulse", int'(done), 0);
    chk("R9", "no restart after done", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, d;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) sh[i] = 8'h00;
    sh[8'h60] = 8'h03; sh[8'h61] = 8'h03;
    for (int i = 8'h62; i <= 8'h6B; i++) sh[i] = 8'hB6;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    for (int i = 8'h5E; i <= 8'h6D; i++) rd_chk("R1", 8'(i));

    do_req(0, 0, 0, 0, 0, 0, 8'h00);
    do_req(1, 1, 1, 1, 1, 0, 8'h00);

    wr_cfg(8'h60, 8'hFF); rd_chk("R3", 8'h60);
    wr_cfg(8'h60, 8'h42); rd_chk("R3", 8'h60);
    do_req(0, 1, 0, 0, 0, 0, 8'h00);
    do_req(1, 0, 1, 0, 0, 0, 8'h00);
    wr_cfg(8'h60, 8'h01);
    do_req(1, 1, 0, 1, 0, 0, 8'h00);
    wr_cfg(8'h60, 8'h03);

    wr_cfg(8'h61, 8'hF0); rd_chk("R2", 8'h61);
    wr_cfg(8'h64, 8'h00); rd_chk("R2", 8'h64);
    do_req(0, 0, 0, 0, 0, 0, 8'h00);
    wr_cfg(8'h6B, 8'hFF); wr_cfg(8'h61, 8'h0F);
    do_req(1, 1, 1, 0, 1, 0, 8'h00);
    wr_cfg(8'h63, 8'h21); wr_cfg(8'h69, 8'h53); wr_cfg(8'h61, 8'h01);
    do_req(1, 0, 0, 1, 0, 0, 8'h00);
    do_req(1, 1, 0, 0, 0, 1, 8'h11);
    rd_chk("R10", 8'h69);
    wr_cfg(8'h70, 8'hAA); rd_chk("R2", 8'h70);
    wr_cfg(8'h5F, 8'h55); rd_chk("R2", 8'h5F);

    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 9) < 3) begin
        a = 8'(8'h5E + $urandom_range(0, 15));
        d = 8'($urandom);
        if (a == 8'h60) d = d | 8'h01;
        wr_cfg(a, d);
        rd_chk("R2/R3", 8'(8'h5E + $urandom_range(0, 15)));
      end else begin
        do_req(1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
               1'($urandom), ($urandom_range(0, 4) == 0), 8'($urandom));
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule